// File: doc/BRIEF.md
# Successive-Difference Charge Extractor

This block sits behind an ADC that digitizes the output of a slow analog integrator. The integrator's time constant is about 128 sample periods. A charge pulse therefore shows up as a single step between two consecutive samples. Between pulses the waveform drifts only slowly. On every accepted sample the block subtracts the previously accepted sample from the current one, which gives a signed 15-bit charge estimate.

Small differences are dropped as noise. The block takes the magnitude of the difference and ORs together every bit at or above a static threshold position. A difference is forwarded only when that OR is set. Otherwise the output data is forced to zero and no strobe is raised.

A two-state controller tracks whether a previous sample exists. It starts in `ST_EMPTY` after reset. The transition `LOAD` (first strobed sample) moves it to `ST_PRIMED`. In `ST_PRIMED` it stays put on every sample (`TAKE`), and only reset returns it to `ST_EMPTY`.

Top module: `chg_extract`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `chg_valid` is 0 and `chg_data` is 0.
- R2: The first strobed sample after reset only primes the previous-sample register and raises no `chg_valid`.
- R3: For each later strobed sample, one clock after the strobe, `chg_data` equals current minus previous accepted sample as a 15-bit two's-complement value.
- R4: A difference is forwarded only when its magnitude has a bit set at position `DROP_BITS` or higher (default 4). This means |diff| ≥ 16 passes and |diff| ≤ 15 is suppressed.
- R5: Whenever `chg_valid` is 0, `chg_data` is 0.
- R6: `chg_valid` is high only in the cycle right after a cycle with `smp_valid` high.
- R7: Suppressed samples still replace the previous sample, so a slow ramp of +3 per sample never produces output.
- R8: Inputs are ignored when `smp_valid` is 0: no output is produced and the previous sample is kept.
- R9: Negative steps are judged by magnitude and output as negative two's-complement values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | SAMPLE_W (14) | Unsigned ADC sample |
| smp_valid | input | 1 | Sample strobe |
| chg_data | output | SAMPLE_W+1 (15) | Signed charge difference, zero when not valid |
| chg_valid | output | 1 | Charge strobe |

## Verification
Some behaviours are checked by the bound checker on every cycle:
- zero data whenever the strobe is low;
- the strobe appearing only after a sample strobe;
- a silent first sample;
- exact agreement of each forwarded value with an independently tracked previous sample;
- the pass/drop decision on both sides of the threshold.

Other behaviours need the bench's scenarios to show them:
- the reset values while reset is held;
- a ramp that must stay silent for several samples because suppressed samples still update the history;
- idle cycles carrying large sample values that must not disturb the history;
- re-priming after a reset in mid-stream.

// File: rtl/chx_pkg.sv
package chx_pkg;
    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_PRIMED = 1'b1
    } chx_state_t;
endpackage

// File: rtl/chx_seq.sv
module chx_seq
    import chx_pkg::*;
#(
    parameter int SAMPLE_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                smp_valid,
    output logic [SAMPLE_W-1:0] prev_q,
    output logic                take
);
    chx_state_t state_q, state_d;

    // state register and history register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            if (smp_valid) prev_q <= smp_data;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (smp_valid) state_d = ST_PRIMED; // LOAD
            end
            ST_PRIMED: begin
                take = smp_valid;                   // TAKE
            end
            default: state_d = ST_EMPTY;
        endcase
    end
endmodule

// File: rtl/chx_diff.sv
module chx_diff #(
    parameter int SAMPLE_W = 14,
    localparam int DW      = SAMPLE_W + 1
) (
    input  logic [SAMPLE_W-1:0] cur,
    input  logic [SAMPLE_W-1:0] prev,
    output logic [DW-1:0]       diff,
    output logic [DW-1:0]       mag
);
    always_comb begin
        diff = {1'b0, cur} - {1'b0, prev};
        mag  = diff[DW-1] ? (~diff + 1'b1) : diff;
    end
endmodule

// File: rtl/chx_gate.sv
module chx_gate #(
    parameter int SAMPLE_W  = 14,
    parameter int DROP_BITS = 4,
    localparam int DW       = SAMPLE_W + 1
) (
    input  logic [DW-1:0] diff,
    input  logic [DW-1:0] mag,
    input  logic          take,
    output logic          pass,
    output logic [DW-1:0] gated
);
    logic above;
    always_comb begin
        above = |(mag >> DROP_BITS);
        pass  = take & above;
        gated = diff & {DW{pass}};
    end
endmodule

// File: rtl/chg_extract.sv
module chg_extract #(
    parameter int SAMPLE_W  = 14,
    parameter int DROP_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                smp_valid,
    output logic [SAMPLE_W:0]   chg_data,
    output logic                chg_valid
);
    localparam int DW = SAMPLE_W + 1;

    logic [SAMPLE_W-1:0] prev_q;
    logic                take;
    logic [DW-1:0]       diff, mag, gated;
    logic                pass;

    chx_seq #(.SAMPLE_W(SAMPLE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
        .prev_q(prev_q), .take(take)
    );

    chx_diff #(.SAMPLE_W(SAMPLE_W)) u_diff (
        .cur(smp_data), .prev(prev_q), .diff(diff), .mag(mag)
    );

    chx_gate #(.SAMPLE_W(SAMPLE_W), .DROP_BITS(DROP_BITS)) u_gate (
        .diff(diff), .mag(mag), .take(take), .pass(pass), .gated(gated)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chg_valid <= 1'b0;
            chg_data  <= '0;
        end else begin
            chg_valid <= pass;
            chg_data  <= gated;
        end
    end
endmodule

// File: rtl/chx_chk.sv
module chx_chk #(
    parameter int SAMPLE_W  = 14,
    parameter int DROP_BITS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [SAMPLE_W-1:0] smp_data,
    input logic                smp_valid,
    input logic [SAMPLE_W:0]   chg_data,
    input logic                chg_valid
);
    localparam int DW = SAMPLE_W + 1;

    logic [SAMPLE_W-1:0] m_prev;
    logic                m_primed, m_took, m_first, m_big;
    logic [DW-1:0]       m_exp, m_d, m_a;

    always_comb begin
        m_d = DW'(smp_data) - DW'(m_prev);
        m_a = m_d[DW-1] ? (DW'(0) - m_d) : m_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_prev <= '0; m_primed <= 1'b0; m_took <= 1'b0;
            m_first <= 1'b0; m_big <= 1'b0; m_exp <= '0;
        end else begin
            m_took  <= smp_valid && m_primed;
            m_first <= smp_valid && !m_primed;
            m_big   <= (m_a >= DW'(1 << DROP_BITS));
            m_exp   <= m_d;
            if (smp_valid) begin
                m_prev   <= smp_data;
                m_primed <= 1'b1;
            end
        end
    end

    AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n) m_first |-> !chg_valid); // R2
    AST_DIFF_MATCH: assert property (@(posedge clk) disable iff (!rst_n) chg_valid |-> chg_data == m_exp); // R3
    AST_SMALL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (m_took && !m_big) |-> !chg_valid); // R4
    AST_BIG_PASSED: assert property (@(posedge clk) disable iff (!rst_n) (m_took && m_big) |-> chg_valid); // R4
    AST_DATA_MASKED: assert property (@(posedge clk) disable iff (!rst_n) !chg_valid |-> chg_data == '0); // R5
    AST_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n) chg_valid |-> $past(smp_valid)); // R6
endmodule

bind chg_extract chx_chk #(.SAMPLE_W(SAMPLE_W), .DROP_BITS(DROP_BITS)) u_chk (.*);

// File: tb/sim_chg_extract.sv
module sim_chg_extract;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] smp_data = '0;
    logic        smp_valid = 1'b0;
    logic [14:0] chg_data;
    logic        chg_valid;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    chg_extract u0 (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
        .chg_data(chg_data), .chg_valid(chg_valid)
    );

    // {req tag, valid, sample, expected valid, expected data}
    localparam int NV = 21;
    localparam logic [34:0] VEC [NV] = '{
        {4'd2, 1'b1, 14'd1000,  1'b0, 15'd0},      // R2 first sample silent
        {4'd4, 1'b1, 14'd1000,  1'b0, 15'd0},      // R4 zero diff
        {4'd4, 1'b1, 14'd1015,  1'b0, 15'd0},      // R4 +15 dropped
        {4'd3, 1'b1, 14'd1031,  1'b1, 15'd16},     // R3 R4 +16 passes
        {4'd6, 1'b1, 14'd1031,  1'b0, 15'd0},      // R6
        {4'd9, 1'b1, 14'd1015,  1'b1, 15'h7FF0},   // R9 -16
        {4'd9, 1'b1, 14'd1000,  1'b0, 15'd0},      // R9 -15 dropped
        {4'd8, 1'b0, 14'd5000,  1'b0, 15'd0},      // R8 idle ignored
        {4'd8, 1'b1, 14'd1500,  1'b1, 15'd500},    // R8 history kept
        {4'd7, 1'b1, 14'd1503,  1'b0, 15'd0},      // R7 ramp
        {4'd7, 1'b1, 14'd1506,  1'b0, 15'd0},      // R7
        {4'd7, 1'b1, 14'd1509,  1'b0, 15'd0},      // R7
        {4'd7, 1'b1, 14'd1512,  1'b0, 15'd0},      // R7
        {4'd7, 1'b1, 14'd1515,  1'b0, 15'd0},      // R7
        {4'd3, 1'b1, 14'd1715,  1'b1, 15'd200},    // R3 step after ramp
        {4'd5, 1'b0, 14'd0,     1'b0, 15'd0},      // R5
        {4'd3, 1'b1, 14'd16383, 1'b1, 15'd14668},  // R3 full scale up
        {4'd9, 1'b1, 14'd0,     1'b1, 15'h4001},   // R9 -16383
        {4'd4, 1'b1, 14'd1,     1'b0, 15'd0},      // R4 +1 dropped
        {4'd4, 1'b1, 14'd8,     1'b0, 15'd0},      // R4 +7 dropped
        {4'd4, 1'b1, 14'd24,    1'b1, 15'd16}      // R4 boundary again
    };

    task automatic check(input string req, input logic av, input logic [14:0] ad,
                         input logic ev, input logic [14:0] ed);
        checks++;
        if (av !== ev || ad !== ed) begin
            errors++;
            $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                     req, av, ad, ev, ed);
        end
    endtask

    task automatic step(input logic v, input logic [13:0] s);
        @(negedge clk);
        smp_valid = v;
        smp_data  = s;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", chg_valid, chg_data, 1'b0, 15'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after release", chg_valid, chg_data, 1'b0, 15'd0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][30], VEC[i][29:16]);
            check($sformatf("R%0d vec %0d", VEC[i][34:31], i),
                  chg_valid, chg_data, VEC[i][15], VEC[i][14:0]);
        end

        // R8 large change without strobe, then R5 check
        step(1'b0, 14'd9000);
        check("R8 idle big change", chg_valid, chg_data, 1'b0, 15'd0);
        step(1'b1, 14'd40);
        check("R8 history unchanged", chg_valid, chg_data, 1'b1, 15'd16);

        // R2 reset mid-stream, re-prime silently
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid reset", chg_valid, chg_data, 1'b0, 15'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 14'd3000);
        check("R2 re-prime", chg_valid, chg_data, 1'b0, 15'd0);
        step(1'b1, 14'd2900);
        check("R9 after re-prime", chg_valid, chg_data, 1'b1, 15'h7F9C);
        step(1'b0, 14'd2900);
        check("R6 drop after strobe", chg_valid, chg_data, 1'b0, 15'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule